// File: doc/BRIEF.md
# Serial Successive-Approximation Conversion Sequencer

This block is the digital side of an 8-bit converter with a serial interface. A host lowers an active-low select, then toggles a serial clock while it presents bits on a data input line. The block waits for a start bit, then collects a short channel-assignment word. It runs a binary search of `DW` steps against the difference value of the selected channel pair. Each search decision goes onto the serial output as soon as it is made, most significant bit first. The finished code is then sent again, least significant bit first. The analog front end is replaced by one `DW`-bit digital level per channel, and the comparator is a digital greater-or-equal test.

The serial clock, select and data input are sampled by a fast system clock `clk_i`, and all timing follows rising and falling serial-clock edges. The serial output is modelled as a value plus an output enable, and `busy_o` marks a conversion in progress. Parameters set the channel count (1, 2, 4 or 8), the code width, whether the hold input for the LSB-first stream is present, and whether the output is MSB-first only.

Top module: `sar_serial_seq`

## Requirements
- R1: While `cs_ni` is low, zeros sampled on `di_i` at rising serial-clock edges are ignored. The first 1 sampled at such an edge is the start bit.
- R2: After the start bit, the block takes 0, 2, 3 or 4 assignment bits for 1, 2, 4 or 8 channels. The first bit received is the mode bit (1 single-ended, 0 differential). The second is the polarity bit `odd`. The remaining bits select the channel pair, most significant bit first.
- R3: The positive channel index is {pair, odd}. In single-ended mode the negative level is 0. In differential mode the negative channel is {pair, ~odd}. With one channel, channel 0 is converted against 0.
- R4: On the falling serial-clock edge after the last assignment bit (or after the start bit when there are none), `busy_o` rises and `do_oe_o` asserts with `do_o` = 0. This leading zero lasts one serial-clock period.
- R5: The next `DW` falling edges drive the search decisions MSB first. The code equals positive minus negative when positive ≥ negative, and is all zeros otherwise.
- R6: `di_i` has no effect from the settle slot until the block is cleared.
- R7: `busy_o` falls on the first rising serial-clock edge after the last decision.
- R8: The LSB-first stream then follows on later falling edges as bits 1 to `DW`-1. Bit 0 is not sent a second time. `do_o` is then driven 0 until `cs_ni` rises.
- R9: With the hold input present, `lsb_hold_i` high keeps `do_o` at its present bit on falling edges. Shifting resumes when it is low.
- R10: `do_oe_o` is low whenever `cs_ni` is high, and while the block is hunting for the start bit or collecting the assignment word.
- R11: The block clears only when `cs_ni` and `sclk_i` are high together. A select cycle without that clear starts no new conversion.
- R12: With `MSB_ONLY` set, the LSB stays on `do_o` after the MSB-first stream until `cs_ni` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Select, active low |
| sclk_i | input | 1 | Serial clock, synchronous to clk_i |
| di_i | input | 1 | Serial data input |
| lsb_hold_i | input | 1 | High holds the LSB-first stream (used when USE_SE=1) |
| levels_i | input | NCH*DW | Channel levels, channel i at bits [i*DW +: DW] |
| do_o | output | 1 | Serial data output value |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |
| busy_o | output | 1 | Conversion in progress |

## Verification
Several properties are checked by the in-line assertions on every cycle. The start of each conversion must carry the leading zero, and `busy_o` may only drop on a rising serial-clock edge. The output may only change on a falling edge while enabled, and stays tri-stated during the hunt and address phases. Each finished code must match the clamped difference from the channel decoder. The bench scenarios cover the parts that span whole transactions: every assignment code against several level sets, equal and reversed inputs, and the exact bit order and count of both streams. They also cover holding the LSB stream, noise on `di_i` during conversion, the refused restart without a clear, and the single-channel MSB-only variant.

// File: rtl/sar_serial_pkg.sv
package sar_serial_pkg;
  typedef enum logic [2:0] {
    ST_HUNT, ST_ADDR, ST_SETTLE, ST_CONV, ST_LSB, ST_TAIL
  } seq_state_e;

  function automatic int addr_bits(int nch);
    if (nch <= 1) return 0;
    else if (nch == 2) return 2;
    else if (nch == 4) return 3;
    else return 4;
  endfunction
endpackage

// File: rtl/sar_serial_mux.sv
module sar_serial_mux #(
  parameter int NCH   = 8,
  parameter int DW    = 8,
  parameter int ABITS = 4,
  parameter int AW    = 4
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [NCH*DW-1:0] levels_i,
  output logic [DW-1:0]     diff_o
);
  logic [DW-1:0] lv [NCH];
  logic [DW-1:0] pos, neg;

  for (genvar i = 0; i < NCH; i++) begin : g_lv
    assign lv[i] = levels_i[i*DW +: DW];
  end

  if (NCH == 1) begin : g_one
    assign pos = lv[0];
    assign neg = '0;
  end else begin : g_multi
    localparam int CW = $clog2(NCH);
    logic [CW-1:0] pidx, nidx;
    if (CW == 1) begin : g_pair
      assign pidx = addr_i[ABITS-2];
      assign nidx = ~addr_i[ABITS-2];
    end else begin : g_sel
      assign pidx = {addr_i[CW-2:0], addr_i[ABITS-2]};
      assign nidx = {addr_i[CW-2:0], ~addr_i[ABITS-2]};
    end
    assign pos = lv[pidx];
    assign neg = addr_i[ABITS-1] ? '0 : lv[nidx];
  end

  // reversed inputs clamp to zero
  assign diff_o = (pos >= neg) ? pos - neg : '0;
endmodule

// File: rtl/sar_serial_step.sv
module sar_serial_step #(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic [DW-1:0] res_i,
  input  logic [BW-1:0] bit_i,
  input  logic [DW-1:0] diff_i,
  output logic [DW-1:0] res_o,
  output logic          dec_o
);
  logic [DW-1:0] trial;
  assign trial = res_i | (DW'(1) << bit_i);
  assign dec_o = (diff_i >= trial);
  assign res_o = dec_o ? trial : res_i;
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_serial_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int DW       = 8,
  parameter bit USE_SE   = 1'b1,
  parameter bit MSB_ONLY = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              di_i,
  input  logic              lsb_hold_i,
  input  logic [NCH*DW-1:0] levels_i,
  output logic              do_o,
  output logic              do_oe_o,
  output logic              busy_o
);
  localparam int ABITS = addr_bits(NCH);
  localparam int AW    = (ABITS > 0) ? ABITS : 1;
  localparam int ACW   = $clog2(ABITS + 2);
  localparam int BW    = $clog2(DW);

  seq_state_e    state_q;
  logic          sclk_q;
  logic [AW-1:0] addr_q;
  logic [ACW-1:0] acnt_q;
  logic [BW-1:0] bcnt_q, scnt_q, scnt_inc;
  logic [DW-1:0] res_q, res_nx, diff_w;
  logic          do_q, oe_q, busy_q, dec_w;
  logic          rise_w, fall_w, clr_w, shift_ok;

  assign rise_w   = sclk_i & ~sclk_q;
  assign fall_w   = ~sclk_i & sclk_q;
  assign clr_w    = cs_ni & sclk_i;
  assign shift_ok = !MSB_ONLY && (!USE_SE || !lsb_hold_i);
  assign scnt_inc = scnt_q + 1'b1;

  sar_serial_mux #(.NCH(NCH), .DW(DW), .ABITS(ABITS), .AW(AW)) u_mux (
    .addr_i(addr_q), .levels_i(levels_i), .diff_o(diff_w)
  );

  sar_serial_step #(.DW(DW)) u_step (
    .res_i(res_q), .bit_i(bcnt_q), .diff_i(diff_w), .res_o(res_nx), .dec_o(dec_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      state_q <= ST_HUNT;
      addr_q  <= '0;
      acnt_q  <= '0;
      bcnt_q  <= '0;
      scnt_q  <= '0;
      res_q   <= '0;
      do_q    <= 1'b0;
      oe_q    <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      if (clr_w) begin
        state_q <= ST_HUNT;
        addr_q  <= '0;
        acnt_q  <= '0;
        bcnt_q  <= '0;
        scnt_q  <= '0;
        res_q   <= '0;
        do_q    <= 1'b0;
        oe_q    <= 1'b0;
        busy_q  <= 1'b0;
      end else if (!cs_ni) begin
        unique case (state_q)
          ST_HUNT: if (rise_w && di_i) begin
            state_q <= (ABITS == 0) ? ST_SETTLE : ST_ADDR;
            acnt_q  <= '0;
          end
          ST_ADDR: if (rise_w) begin
            addr_q <= AW'({addr_q, di_i});
            acnt_q <= acnt_q + 1'b1;
            if (acnt_q == ACW'(ABITS - 1)) state_q <= ST_SETTLE;
          end
          ST_SETTLE: if (fall_w) begin
            busy_q  <= 1'b1;
            oe_q    <= 1'b1;
            do_q    <= 1'b0;
            res_q   <= '0;
            bcnt_q  <= BW'(DW - 1);
            state_q <= ST_CONV;
          end
          ST_CONV: if (fall_w) begin
            res_q  <= res_nx;
            do_q   <= dec_w;
            scnt_q <= '0;
            if (bcnt_q == '0) state_q <= ST_LSB;
            else bcnt_q <= bcnt_q - 1'b1;
          end
          ST_LSB: begin
            if (rise_w) busy_q <= 1'b0;
            if (fall_w && shift_ok) begin
              if (scnt_q == BW'(DW - 1)) begin
                state_q <= ST_TAIL;
                do_q    <= 1'b0;
              end else begin
                scnt_q <= scnt_inc;
                do_q   <= res_q[scnt_inc];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign do_o    = do_q;
  assign do_oe_o = oe_q & ~cs_ni;
  assign busy_o  = busy_q;

  // R4
  settle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (do_oe_o && !do_o));
  // R7
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(rise_w));
  // R5
  result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LSB && $past(state_q) == ST_CONV) |-> (res_q == diff_w));
  // R8
  do_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_oe_o && $past(do_oe_o) && !$past(fall_w)) |-> $stable(do_o));
  // R10
  idle_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT || state_q == ST_ADDR) |-> !do_oe_o);
endmodule

// File: tb/sim_sar_serial_seq.sv
module sim_sar_serial_seq;
  localparam int NCH = 8;
  localparam int DW  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, di = 1'b0, hold = 1'b0;
  logic [NCH*DW-1:0] levels = '0;
  logic [DW-1:0] level1 = 8'd201;
  logic do0, oe0, busy0, do1, oe1, busy1;
  int nvec = 0, nfail = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sar_serial_seq #(.NCH(NCH), .DW(DW), .USE_SE(1'b1), .MSB_ONLY(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .di_i(di),
    .lsb_hold_i(hold), .levels_i(levels), .do_o(do0), .do_oe_o(oe0), .busy_o(busy0));

  sar_serial_seq #(.NCH(1), .DW(DW), .USE_SE(1'b0), .MSB_ONLY(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .di_i(di),
    .lsb_hold_i(1'b0), .levels_i(level1), .do_o(do1), .do_oe_o(oe1), .busy_o(busy1));

  task automatic chk(input logic act, input logic exp, input string req);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic d);
    @(negedge clk) di = d; sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_tr(input bit clear);
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(oe0, 1'b0, "R10 oe after cs rise");
    if (clear) begin
      sclk = 1'b1; repeat (4) @(negedge clk);
      sclk = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  function automatic logic [DW-1:0] expect_code(input logic [3:0] a);
    logic [2:0] pi, ni;
    logic [DW-1:0] p, n;
    pi = {a[1:0], a[2]};
    ni = {a[1:0], ~a[2]};
    p = levels[pi*DW +: DW];
    n = a[3] ? '0 : levels[ni*DW +: DW];
    return (p >= n) ? p - n : '0;
  endfunction

  // full transaction on u0: nz leading zeros, address a, hold_n hold periods, noisy di
  task automatic run(input logic [3:0] a, input int nz, input int hold_n, input bit noise);
    logic [DW-1:0] e;
    e = expect_code(a);
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nz; i++) begin
      tick(1'b0);
      chk(oe0, 1'b0, "R1 R10 no output while hunting");
    end
    tick(1'b1);
    for (int i = 3; i >= 0; i--) begin
      if (i == 0) chk(oe0, 1'b0, "R10 hi-z during address");
      tick(a[i]);
    end
    chk(busy0, 1'b1, "R4 busy at settle");
    chk(oe0, 1'b1, "R4 oe at settle");
    chk(do0, 1'b0, "R4 leading zero");
    for (int b = DW - 1; b >= 0; b--) begin
      tick(noise ? ~e[b] : 1'b0);
      chk(do0, e[b], noise ? "R6 R5 msb stream with noisy di" : "R2 R3 R5 msb stream");
    end
    chk(busy0, 1'b1, "R7 busy until next rise");
    if (hold_n > 0) begin
      hold = 1'b1;
      for (int h = 0; h < hold_n; h++) begin
        tick(1'b0);
        chk(do0, e[0], "R9 lsb held");
        if (h == 0) chk(busy0, 1'b0, "R7 busy fell");
      end
      hold = 1'b0;
    end
    for (int b = 1; b < DW; b++) begin
      tick(1'b1);
      chk(do0, e[b], "R8 lsb stream");
      if (b == 1 && hold_n == 0) chk(busy0, 1'b0, "R7 busy fell");
    end
    for (int t = 0; t < 2; t++) begin
      tick(1'b1);
      chk(do0, 1'b0, "R8 low tail");
      chk(oe0, 1'b1, "R8 tail driven");
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(oe0, 1'b0, "R10 reset oe");
    chk(busy0, 1'b0, "R7 reset busy");

    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < NCH; i++) begin
        case (k)
          0: levels[i*DW +: DW] = DW'((i * 37 + 13) % 256);
          1: levels[i*DW +: DW] = DW'((i / 2) * 50 + 5);
          default: levels[i*DW +: DW] = i[0] ? 8'd255 : 8'd0;
        endcase
      end
      for (int a = 0; a < 16; a++) begin
        run(4'(a), (a % 3), 0, 1'b0);
        finish_tr(1'b1);
      end
    end

    for (int i = 0; i < NCH; i++) levels[i*DW +: DW] = DW'(200 - i * 23);
    run(4'b0110, 1, 3, 1'b0);
    finish_tr(1'b1);
    run(4'b1011, 0, 0, 1'b1);
    finish_tr(1'b1);

    // R11: select cycle without clear must not restart
    run(4'b1000, 0, 0, 1'b0);
    finish_tr(1'b0);
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    tick(1'b1);
    for (int i = 0; i < 4; i++) tick(1'b1);
    for (int t = 0; t < 10; t++) begin
      tick(1'b0);
      chk(busy0, 1'b0, "R11 no restart without clear");
      chk(do0, 1'b0, "R11 output stays low");
    end
    finish_tr(1'b1);
    run(4'b1101, 2, 0, 1'b0);
    finish_tr(1'b1);

    // R12: single channel, no address, MSB only
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    tick(1'b0);
    chk(oe1, 1'b0, "R12 hi-z before start");
    tick(1'b1);
    chk(busy1, 1'b1, "R12 settle right after start");
    chk(do1, 1'b0, "R12 leading zero");
    for (int b = DW - 1; b >= 0; b--) begin
      tick(1'b0);
      chk(do1, level1[b], "R12 msb stream");
    end
    for (int t = 0; t < 4; t++) begin
      tick(1'b0);
      chk(do1, level1[0], "R12 lsb kept");
    end
    finish_tr(1'b1);
    chk(oe1, 1'b0, "R12 hi-z after cs");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule